// File: doc/BRIEF.md
# Tag-Aligning Complex Butterfly

This block is the add/subtract core of one stage in a pipelined FFT whose data words are scaled one word at a time. Every complex word carries a small unsigned scale tag. The tag says how many times the word has been halved since it entered the pipeline, so the value the word stands for is its data times two to the power of its tag. Words that meet in a butterfly usually carry different tags.

The block compares the two tags and brings the word with the smaller tag to the scale of the other. It does this with an arithmetic right shift of both of that word's parts, by the size of the tag gap. It then forms the sum and the difference one bit wider than the inputs, so neither result can overflow. Both results take the larger tag.

Alignment is done in the combinational path of the stage. No words are gathered for normalisation. Results are registered, so each accepted pair appears on the outputs one clock later.

Top module: `tag_align_bfly`

## Requirements
- R1: Each operand has an unsigned tag of TW bits, and signed two's-complement real and imaginary parts of DW bits each. The defaults are TW=4 and DW=12.
- R2: Both outputs carry the same tag, equal to the larger of the two input tags.
- R3: The operand with the smaller tag has its real and imaginary parts arithmetically right-shifted by the absolute tag difference. The other operand is not shifted. When the tags are equal, neither operand is shifted.
- R4: A tag difference of DW or more reduces the shifted part to its sign: 0 for non-negative values and -1 for negative values.
- R5: The sum output is A+B and the difference output is A−B, both taken after alignment. Real and imaginary results are DW+1 bits wide and signed, and they never wrap.
- R6: A pair presented with in_vld high appears on the outputs one clock later, with out_vld high. out_vld is low in every cycle that follows an edge where in_vld was low.
- R7: While in_vld is low, the output tags and data keep their previous values.
- R8: While rst_n is low, out_vld and all output tags and data are zero.
- R9: For every output part, data×2^tag differs from the exact result on the unscaled values by less than 2^tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Input pair is valid |
| a_tag | input | TW | Scale tag of operand A |
| a_re | input | DW | Real part of A |
| a_im | input | DW | Imaginary part of A |
| b_tag | input | TW | Scale tag of operand B |
| b_re | input | DW | Real part of B |
| b_im | input | DW | Imaginary part of B |
| out_vld | output | 1 | Outputs hold a new result |
| sum_tag | output | TW | Tag of the sum |
| sum_re | output | DW+1 | Real part of A+B |
| sum_im | output | DW+1 | Imaginary part of A+B |
| dif_tag | output | TW | Tag of the difference |
| dif_re | output | DW+1 | Real part of A−B |
| dif_im | output | DW+1 | Imaginary part of A−B |

## Verification
The stimulus covers several tag relations:
- Equal tags show that no shift is applied.
- A larger tag on A, and then on B, shows that the shift goes to the correct operand and is not mirrored.
- Tag gaps of DW or more expose a shifter that wraps or drops the sign.

Full-scale inputs of the same sign and of opposite signs stress the extra result bit. Idle gaps between valid pairs show whether the outputs hold. Random pairs are also checked against the exact result on the unscaled values, to confirm that the only error left is the truncation from the shift.

// File: rtl/tag_align_bfly.sv
module tag_align_bfly #(
  parameter int DW = 12,
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic [TW-1:0] a_tag,
  input  logic [DW-1:0] a_re,
  input  logic [DW-1:0] a_im,
  input  logic [TW-1:0] b_tag,
  input  logic [DW-1:0] b_re,
  input  logic [DW-1:0] b_im,
  output logic          out_vld,
  output logic [TW-1:0] sum_tag,
  output logic [DW:0]   sum_re,
  output logic [DW:0]   sum_im,
  output logic [TW-1:0] dif_tag,
  output logic [DW:0]   dif_re,
  output logic [DW:0]   dif_im
);
  localparam int OW = DW + 1;
  localparam int MAXSH = DW - 1;

  logic [TW:0]   tdiff;
  logic          a_big;
  logic [TW-1:0] gap;
  logic [TW-1:0] sh;
  logic [TW-1:0] sh_a, sh_b;
  logic [TW-1:0] top_tag;

  assign tdiff   = {1'b0, a_tag} - {1'b0, b_tag};
  assign a_big   = ~tdiff[TW];
  assign gap     = a_big ? tdiff[TW-1:0] : (b_tag - a_tag);
  assign sh      = (32'(gap) > MAXSH) ? TW'(MAXSH) : gap;
  assign sh_a    = a_big ? '0 : sh;
  assign sh_b    = a_big ? sh : '0;
  assign top_tag = a_big ? a_tag : b_tag;

  logic signed [DW-1:0] ar_s, ai_s, br_s, bi_s;
  assign ar_s = $signed(a_re) >>> sh_a;
  assign ai_s = $signed(a_im) >>> sh_a;
  assign br_s = $signed(b_re) >>> sh_b;
  assign bi_s = $signed(b_im) >>> sh_b;

  logic signed [OW-1:0] s_re, s_im, d_re, d_im;
  assign s_re = OW'(ar_s) + OW'(br_s);
  assign s_im = OW'(ai_s) + OW'(bi_s);
  assign d_re = OW'(ar_s) - OW'(br_s);
  assign d_im = OW'(ai_s) - OW'(bi_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      sum_tag <= '0;
      dif_tag <= '0;
      sum_re  <= '0;
      sum_im  <= '0;
      dif_re  <= '0;
      dif_im  <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        sum_tag <= top_tag;
        dif_tag <= top_tag;
        sum_re  <= s_re;
        sum_im  <= s_im;
        dif_re  <= d_re;
        dif_im  <= d_im;
      end
    end
  end

  p_vld_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);
  p_vld_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld);
  p_tag_max_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> (sum_tag == dif_tag) && (sum_tag >= $past(a_tag)) &&
               (sum_tag >= $past(b_tag)) &&
               ((sum_tag == $past(a_tag)) || (sum_tag == $past(b_tag))));
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> $stable(sum_tag) && $stable(dif_tag) && $stable(sum_re) &&
                $stable(sum_im) && $stable(dif_re) && $stable(dif_im));
  p_noshift_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && a_tag == b_tag) |=>
      ($signed(sum_re) == $signed($past(a_re)) + $signed($past(b_re))) &&
      ($signed(dif_im) == $signed($past(a_im)) - $signed($past(b_im))));
endmodule

// File: tb/tag_align_bfly_test.sv
`timescale 1ns/1ps
module tag_align_bfly_test;
  localparam int DW = 12;
  localparam int TW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_vld = 1'b0;
  logic [TW-1:0] a_tag = '0, b_tag = '0;
  logic [DW-1:0] a_re = '0, a_im = '0, b_re = '0, b_im = '0;
  logic out_vld;
  logic [TW-1:0] sum_tag, dif_tag;
  logic [DW:0] sum_re, sum_im, dif_re, dif_im;

  always #4 clk = ~clk;

  tag_align_bfly #(.DW(DW), .TW(TW)) uut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld),
    .a_tag(a_tag), .a_re(a_re), .a_im(a_im),
    .b_tag(b_tag), .b_re(b_re), .b_im(b_im),
    .out_vld(out_vld), .sum_tag(sum_tag), .sum_re(sum_re), .sum_im(sum_im),
    .dif_tag(dif_tag), .dif_re(dif_re), .dif_im(dif_im));

  int checks = 0, errors = 0;
  bit done = 0;
  int e_vld = 0, e_tag = 0;
  int e_v[4] = '{0, 0, 0, 0};
  longint ideal[4] = '{0, 0, 0, 0};
  string cur_req = "R8";

  function automatic int fdiv(int x, int k);
    int p = 1 << k;
    int q = x / p;
    if (x < 0 && q * p != x) q = q - 1;
    return q;
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare();
    int act[4];
    act[0] = $signed(sum_re); act[1] = $signed(sum_im);
    act[2] = $signed(dif_re); act[3] = $signed(dif_im);
    chk("R6", "out_vld", out_vld, e_vld);
    chk("R2", "sum_tag", sum_tag, e_tag);
    chk("R2", "dif_tag", dif_tag, e_tag);
    for (int i = 0; i < 4; i++) begin
      longint err;
      chk(cur_req, $sformatf("part%0d", i), act[i], e_v[i]);
      if (e_vld != 0) begin
        // R9: scaled output within one output LSB of the exact result
        err = ideal[i] - longint'(act[i]) * (longint'(1) << sum_tag);
        checks++;
        if (err >= (longint'(1) << sum_tag) || err <= -(longint'(1) << sum_tag)) begin
          errors++;
          $display("FAIL R9 part%0d actual=%0d expected=%0d", i,
                   longint'(act[i]) * (longint'(1) << sum_tag), ideal[i]);
        end
      end
    end
  endtask

  task automatic step(bit v, int at, int ar, int ai, int bt, int br, int bi, string req);
    @(negedge clk);
    compare();
    in_vld = v;
    a_tag = TW'(at); a_re = DW'(ar); a_im = DW'(ai);
    b_tag = TW'(bt); b_re = DW'(br); b_im = DW'(bi);
    e_vld = v;
    if (v) begin
      int t = (at > bt) ? at : bt;
      int sar = fdiv(ar, t - at), sai = fdiv(ai, t - at);
      int sbr = fdiv(br, t - bt), sbi = fdiv(bi, t - bt);
      e_tag = t;
      e_v[0] = sar + sbr; e_v[1] = sai + sbi;
      e_v[2] = sar - sbr; e_v[3] = sai - sbi;
      ideal[0] = (longint'(ar) << at) + (longint'(br) << bt);
      ideal[1] = (longint'(ai) << at) + (longint'(bi) << bt);
      ideal[2] = (longint'(ar) << at) - (longint'(br) << bt);
      ideal[3] = (longint'(ai) << at) - (longint'(bi) << bt);
      cur_req = req;
    end else begin
      cur_req = "R7";
    end
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk);
      compare();  // R8 reset state
    end
    rst_n = 1'b1;
    step(1, 3, 100, -200, 3, -50, 75, "R1/R3 equal");
    step(1, 5, 1000, -1000, 2, 801, -803, "R3 a larger");
    step(1, 1, -37, 555, 4, 1999, -2000, "R3 b larger");
    step(0, 9, 7, 7, 0, 7, 7, "R7");
    step(0, 0, 1, 2, 9, 3, 4, "R7");
    step(1, 15, 5, -5, 0, 2047, -2048, "R4 gap15");
    step(1, 0, -1, 1, 12, 300, -300, "R4 gap12");
    step(1, 11, 17, 19, 0, -2048, 2047, "R4 gap11");
    step(1, 2, 2047, -2048, 2, 2047, -2048, "R5 same sign");
    step(1, 6, 2047, -2048, 6, -2048, 2047, "R5 opposite");
    step(1, 7, -2048, -2048, 7, -2048, -2048, "R5 min");
    step(0, 0, 0, 0, 0, 0, 0, "R7");
    for (int n = 0; n < 300; n++) begin
      step(($urandom % 4) != 0, $urandom % 16, int'($urandom % 4096) - 2048,
           int'($urandom % 4096) - 2048, $urandom % 16,
           int'($urandom % 4096) - 2048, int'($urandom % 4096) - 2048, "R3/R5 random");
    end
    step(0, 0, 0, 0, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 0, 0, 0, "R7");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R6 watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule